// File: doc/BRIEF.md
# Receive-only I2C command slave

This block sits on a two-wire bus as a slave that only accepts writes. A fast system clock samples the bus clock and data lines through synchronizers, finds START, repeated START and STOP conditions, and compares the first byte after a START with a seven-bit address. That address is made of a fixed five-bit prefix `10101` and two strap pins. The block never generates the bus clock and never drives the data line high. It acknowledges by pulling the line low through an output enable.

Once its address is acknowledged, the slave expects three more bytes: a channel pointer, then the high data byte, then the low data byte. It acknowledges each one. When the last byte has been acknowledged, it presents a command on its outputs and raises a strobe for one cycle. The command is the channel number, the register select and a 14-bit data word. A START or STOP that arrives before the frame is complete discards the frame.

Top module: `i2c_dac_cmd_rx`

## Requirements
- R1: A synchronous active-high reset leaves `sda_oe` low, `cmd_valid` low and all command outputs at zero.
- R2: A first byte after START equal to `{10101, addr_pin[1], addr_pin[0], 0}` (bit 7 sent first, the last bit being R/W) is acknowledged: `sda_oe` is high during the ninth SCL high phase.
- R3: A first byte whose seven address bits differ from the strapped address is not acknowledged. Every byte after it is also not acknowledged until the next START.
- R4: A matching address with the R/W bit at 1 is not acknowledged. The slave returns to idle and acknowledges no further byte of that transfer.
- R5: After an acknowledged address, the pointer, high and low data bytes are each acknowledged. The channel is the pointer's low six bits; the pointer's top two bits are discarded.
- R6: After the ninth clock of the low data byte, `cmd_valid` pulses. At the same time `cmd_chan` = pointer[5:0], `cmd_reg` = high byte[7:6], and `cmd_data` = {high byte[5:0], low byte}.
- R7: A STOP before the low data byte is acknowledged ends the frame with no strobe, and the command outputs keep their previous values.
- R8: A repeated START in the middle of a frame restarts address matching without a STOP, and a complete frame after it is accepted normally.
- R9: `sda_oe` changes only while SCL is low.
- R10: `cmd_valid` is high for exactly one clock cycle per accepted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_pin | input | 2 | Strap pins giving the two low address bits |
| sda_oe | output | 1 | High pulls the data line low |
| cmd_chan | output | 6 | Channel of the last accepted command |
| cmd_reg | output | 2 | Register select of the last accepted command |
| cmd_data | output | 14 | Data word of the last accepted command |
| cmd_valid | output | 1 | One-cycle strobe for a new command |

## Verification
Every result follows from an SCL or SDA edge seen at the pins. A result appears on the third clock edge after that pin edge: two synchronizer stages, then the state register. This applies to the acknowledge enable after the falling clock that ends the eighth bit, to its release after the ninth, and to the command strobe. The bench holds each SCL phase for eight system cycles and samples the acknowledge four cycles into the ninth high phase, so every check falls well after its result has settled. The strobe and its command fields are captured on falling clock edges by a monitor. Each frame task then compares the captured count and values once the frame has ended.

// File: rtl/i2c_dac_cmd_rx.sv
module i2c_dac_cmd_rx #(
  parameter logic [4:0] ADDR_PREFIX = 5'b10101,
  parameter int         CHAN_W      = 6,
  parameter int         DATA_W      = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_pin,
  output logic              sda_oe,
  output logic [CHAN_W-1:0] cmd_chan,
  output logic [1:0]        cmd_reg,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_valid
);
  localparam int HI_W = DATA_W - 8;
  localparam logic [1:0] S_IDLE = 2'd0, S_RX = 2'd1, S_ACK = 2'd2;

  logic [2:0] scl_p, sda_p;
  logic [1:0] st;
  logic [3:0] bitcnt;
  logic [1:0] byte_idx;
  logic [7:0] shreg, hi_q;
  logic [CHAN_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  wire scl_now  = scl_p[1];
  wire scl_old  = scl_p[2];
  wire sda_now  = sda_p[1];
  wire sda_old  = sda_p[2];
  wire scl_rise = scl_now & ~scl_old;
  wire scl_fall = ~scl_now & scl_old;
  wire start_c  = scl_now & scl_old & sda_old & ~sda_now;
  wire stop_c   = scl_now & scl_old & ~sda_old & sda_now;
  wire addr_ok  = (shreg == {ADDR_PREFIX, addr_pin, 1'b0});

  always_ff @(posedge clk) begin
    cmd_valid <= 1'b0;
    if (rst) begin
      st       <= S_IDLE;
      sda_oe   <= 1'b0;
      bitcnt   <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      hi_q     <= '0;
      ptr_q    <= '0;
      cmd_chan <= '0;
      cmd_reg  <= '0;
      cmd_data <= '0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      st       <= S_RX;
      sda_oe   <= 1'b0;
      bitcnt   <= '0;
      byte_idx <= '0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_now};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (byte_idx != 2'd0 || addr_ok) begin
              sda_oe <= 1'b1;
              st     <= S_ACK;
              if (byte_idx == 2'd1) ptr_q <= shreg[CHAN_W-1:0];
              if (byte_idx == 2'd2) hi_q  <= shreg;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            if (byte_idx == 2'd3) begin
              cmd_valid <= 1'b1;
              cmd_chan  <= ptr_q;
              cmd_reg   <= hi_q[7:6];
              cmd_data  <= {hi_q[HI_W-1:0], shreg};
              st        <= S_IDLE;
            end else begin
              byte_idx <= byte_idx + 2'd1;
              st       <= S_RX;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_dac_cmd_rx_chk.sv
module i2c_dac_cmd_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic        scl_i,
  input logic        sda_oe,
  input logic        cmd_valid,
  input logic [5:0]  cmd_chan,
  input logic [1:0]  cmd_reg,
  input logic [13:0] cmd_data,
  input logic [1:0]  st
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && !cmd_valid));

  p_idle_no_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0) |-> !sda_oe);

  p_strobe_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(sda_oe));

  p_hold_outputs_r7: assert property (@(posedge clk) disable iff (rst)
    !($stable(cmd_chan) && $stable(cmd_reg) && $stable(cmd_data)) |-> cmd_valid);

  p_ack_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
endmodule

bind i2c_dac_cmd_rx i2c_dac_cmd_rx_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
  .cmd_chan(cmd_chan), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .st(st)
);

// File: tb/sim_i2c_dac_cmd_rx.sv
module sim_i2c_dac_cmd_rx;
  logic clk = 0, rst = 1;
  logic m_scl = 1, m_sda = 1;
  logic [1:0] addr_pin = 2'b10;
  logic sda_oe, cmd_valid;
  logic [5:0] cmd_chan;
  logic [1:0] cmd_reg;
  logic [13:0] cmd_data;
  wire sda_line = m_sda & ~sda_oe;

  int nchecks = 0, nfail = 0;
  int vcnt = 0, wide = 0, oe_bad = 0;
  logic prev_valid = 0, prev_oe = 0;
  logic [5:0] cap_chan;
  logic [1:0] cap_reg;
  logic [13:0] cap_data;

  always #5 clk = ~clk;

  i2c_dac_cmd_rx u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .addr_pin(addr_pin),
    .sda_oe(sda_oe), .cmd_chan(cmd_chan), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .cmd_valid(cmd_valid)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid) begin
        vcnt++;
        cap_chan = cmd_chan;
        cap_reg  = cmd_reg;
        cap_data = cmd_data;
        if (prev_valid) wide++;
      end
      if (sda_oe !== prev_oe && m_scl) oe_bad++;
    end
    prev_valid = cmd_valid;
    prev_oe    = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1; wait_clk(8);
    m_scl = 1; wait_clk(8);
    m_sda = 0; wait_clk(8);
    m_scl = 0; wait_clk(8);
  endtask

  task automatic bus_stop;
    m_sda = 0; wait_clk(8);
    m_scl = 1; wait_clk(8);
    m_sda = 1; wait_clk(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_clk(8);
      m_scl = 1;    wait_clk(8);
      m_scl = 0;    wait_clk(8);
    end
    m_sda = 1; wait_clk(8);
    m_scl = 1; wait_clk(4);
    acked = (sda_line == 1'b0);
    wait_clk(4);
    m_scl = 0; wait_clk(8);
  endtask

  task automatic t_reset;
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 cmd_chan", cmd_chan, 0);
    chk("R1 cmd_reg", cmd_reg, 0);
    chk("R1 cmd_data", cmd_data, 0);
  endtask

  task automatic t_full_write;
    logic a;
    int v0 = vcnt;
    bus_start;
    send_byte(8'hAC, a); chk("R2 address ack", a, 1);
    send_byte(8'h15, a); chk("R5 pointer ack", a, 1);
    send_byte(8'h9A, a); chk("R5 high byte ack", a, 1);
    chk("R7 no early strobe", vcnt - v0, 0);
    send_byte(8'h3C, a); chk("R5 low byte ack", a, 1);
    bus_stop;
    chk("R6 one strobe", vcnt - v0, 1);
    chk("R6 channel", cap_chan, 6'h15);
    chk("R6 register", cap_reg, 2'd2);
    chk("R6 data", cap_data, 14'h1A3C);
  endtask

  task automatic t_other_strap;
    logic a;
    int v0 = vcnt;
    addr_pin = 2'b01;
    wait_clk(4);
    bus_start;
    send_byte(8'hAA, a); chk("R2 address ack other strap", a, 1);
    send_byte(8'hC7, a); chk("R5 pointer ack", a, 1);
    send_byte(8'h7F, a); chk("R5 high byte ack", a, 1);
    send_byte(8'h01, a); chk("R5 low byte ack", a, 1);
    bus_stop;
    chk("R6 one strobe", vcnt - v0, 1);
    chk("R5 pointer top bits dropped", cap_chan, 6'h07);
    chk("R6 register", cap_reg, 2'd1);
    chk("R6 data", cap_data, 14'h3F01);
    addr_pin = 2'b10;
    wait_clk(4);
  endtask

  task automatic t_wrong_addr;
    logic a;
    int v0 = vcnt;
    bus_start;
    send_byte(8'hAE, a); chk("R3 wrong address nack", a, 0);
    send_byte(8'h05, a); chk("R3 later byte nack", a, 0);
    send_byte(8'h12, a); chk("R3 later byte nack", a, 0);
    send_byte(8'h34, a); chk("R3 later byte nack", a, 0);
    bus_stop;
    chk("R3 no strobe", vcnt - v0, 0);
    chk("R3 channel kept", cmd_chan, 6'h07);
    bus_start;
    send_byte(8'h2C, a); chk("R3 prefix mismatch nack", a, 0);
    bus_stop;
  endtask

  task automatic t_read;
    logic a;
    int v0 = vcnt;
    bus_start;
    send_byte(8'hAD, a); chk("R4 read nack", a, 0);
    send_byte(8'h01, a); chk("R4 later byte nack", a, 0);
    send_byte(8'h02, a); chk("R4 later byte nack", a, 0);
    send_byte(8'h03, a); chk("R4 later byte nack", a, 0);
    bus_stop;
    chk("R4 no strobe", vcnt - v0, 0);
  endtask

  task automatic t_stop_abort;
    logic a;
    int v0 = vcnt;
    bus_start;
    send_byte(8'hAC, a); chk("R7 address ack", a, 1);
    send_byte(8'h22, a);
    send_byte(8'hFF, a); chk("R7 high byte ack", a, 1);
    bus_stop;
    wait_clk(10);
    chk("R7 no strobe", vcnt - v0, 0);
    chk("R7 channel kept", cmd_chan, 6'h07);
    chk("R7 register kept", cmd_reg, 2'd1);
    chk("R7 data kept", cmd_data, 14'h3F01);
  endtask

  task automatic t_restart;
    logic a;
    int v0 = vcnt;
    bus_start;
    send_byte(8'hAC, a);
    send_byte(8'h11, a); chk("R8 pointer ack before restart", a, 1);
    bus_start;
    chk("R8 no strobe on restart", vcnt - v0, 0);
    send_byte(8'hAC, a); chk("R8 address ack after restart", a, 1);
    send_byte(8'h3F, a); chk("R8 pointer ack", a, 1);
    send_byte(8'h40, a); chk("R8 high byte ack", a, 1);
    send_byte(8'hFF, a); chk("R8 low byte ack", a, 1);
    bus_stop;
    chk("R8 one strobe", vcnt - v0, 1);
    chk("R8 channel", cap_chan, 6'h3F);
    chk("R8 register", cap_reg, 2'd1);
    chk("R8 data", cap_data, 14'h00FF);
  endtask

  task automatic finish_run;
    chk("R9 sda_oe changed with SCL high", oe_bad, 0);
    chk("R10 strobe wider than one cycle", wide, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  initial begin
    #1000000;
    nchecks++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 0;
    wait_clk(2);
    t_reset;
    t_full_write;
    t_other_strap;
    t_wrong_addr;
    t_read;
    t_stop_abort;
    t_restart;
    finish_run;
  end
endmodule